// File: doc/BRIEF.md
# DMA Software Request and Channel Completion Flag Register

This block is the control and status register slice that sits beside a three-channel DMA transfer engine serving eight request sources. Software writes a byte of request bits, one per source. Each bit that is set raises a service request for its source. The request is only acted on by a channel whose transfer enable is already on and whose source selection names that source. While neither is true, the request stays pending. The same bits let test software fake peripheral requests without any peripheral taking part.

The block also keeps one completion flag per channel. The transfer engine sets a flag with a single-cycle pulse, either when the whole transfer is finished or when one loop of it ends. A flag whose channel interrupt enable is on drives the CPU interrupt line. Software can only take a flag down with a handshake: it first reads the flag register while the flag shows 1, and then writes 0 to that bit. A stray write alone never loses an event.

The CPU port is a plain single-cycle strobe interface with no back-pressure. `bus_sel` picks the register: 0 is the request byte and 1 is the flag register, whose flags sit in bits [2:0]. Read data is combinational from the selected register. Channel enables, interrupt enables and source selections come from a neighbouring control register and enter as plain level inputs.

Top module: `dma_req_flag_regs`

## Requirements
- R1: After reset, `svc_req` is 0, all three completion flags read 0 at `bus_sel`=1, and `irq` is 0.
- R2: A write with `bus_sel`=0 loads `bus_wdata` into the request byte on that clock edge. `svc_req` shows the new value from the next cycle, and `bus_rdata` returns it while `bus_sel`=0.
- R3: Writing 0 to a request bit withdraws that source's service request from the next cycle.
- R4: `chan_start[c]` is high exactly when `chan_xfer_en[c]` is 1 and the request bit chosen by the 3-bit field `chan_src[3c+2:3c]` is 1. Otherwise the request is held and no start is signalled.
- R5: A pulse on `done_pulse[c]` or `loop_pulse[c]` sets flag c from the next cycle. Flag c reads at `bus_rdata[c]` with `bus_sel`=1, and bits [7:3] read 0.
- R6: A flag clears only when a read with `bus_sel`=1 has shown it as 1, and the next write with `bus_sel`=1 carries 0 in that bit. A read that shows the flag as 0 does not arm it.
- R7: A write of 0 to a set flag with no earlier arming read leaves the flag at 1.
- R8: Writing 1 to a flag bit never changes it. A flag that is clear stays clear.
- R9: A completion pulse in the same cycle as a clearing write wins, and the flag stays 1.
- R10: `irq` is a register that takes the OR over channels of (flag AND `chan_irq_en`). It follows a change of flag or enable one cycle later.
- R11: Any write with `bus_sel`=1 drops every arming, whatever data it carries. A later write of 0 then has no effect until a new read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register select: 0 request byte, 1 flag register |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle, arms set flags |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| chan_xfer_en | input | 3 | Per-channel transfer enable |
| chan_irq_en | input | 3 | Per-channel interrupt enable |
| chan_src | input | 9 | Per-channel source number, 3 bits per channel |
| done_pulse | input | 3 | Transfer-complete pulse per channel |
| loop_pulse | input | 3 | Loop-end pulse per channel |
| svc_req | output | 8 | Pending service request per source |
| chan_start | output | 3 | Request accepted by an enabled channel |
| irq | output | 1 | CPU interrupt request |

## Verification
A lost or stuck arming bit shows at the ports on the first write of 0 to the flag register. The flag either drops when it should hold, or holds when it should drop, and the readback one cycle later exposes it. A flag register that misses a completion pulse, or lets a write win over a pulse, is visible in the readback the cycle after. The interrupt line shows the same fault one cycle later still. A corrupted request byte appears on `svc_req` and `chan_start` in the cycle after the write that caused it.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
  localparam int unsigned DEF_NUM_SRC = 8;
  localparam int unsigned DEF_NUM_CH  = 3;
  localparam int unsigned DEF_DW      = 8;

  typedef enum logic {
    SEL_SWREQ = 1'b0,
    SEL_FLAGS = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/dma_swreq_reg.sv
module dma_swreq_reg #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned DW      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [DW-1:0]      wdata,
  output logic [NUM_SRC-1:0] req_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)     req_q <= '0;
    else if (wr_en) req_q <= wdata[NUM_SRC-1:0];
  end

  // R2
  swreq_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> req_q == $past(wdata[NUM_SRC-1:0]));
endmodule

// File: rtl/dma_done_flag.sv
module dma_done_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_en,
  input  logic wr_en,
  input  logic wbit,
  input  logic set_evt,
  output logic flag_q
);
  logic arm_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                  arm_q <= 1'b0;
    else if (wr_en)              arm_q <= 1'b0;
    else if (rd_en && flag_q)    arm_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                           flag_q <= 1'b0;
    else if (set_evt)                     flag_q <= 1'b1;
    else if (wr_en && arm_q && !wbit)     flag_q <= 1'b0;
  end

  // R9
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q);

  // R8
  no_sw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_q && !set_evt) |=> !flag_q);

  // R7
  hold_without_zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(wr_en && !wbit)) |=> flag_q);
endmodule

// File: rtl/dma_irq_merge.sv
module dma_irq_merge #(
  parameter int unsigned NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] flags,
  input  logic [NUM_CH-1:0] en,
  output logic              irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(flags & en);
  end

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(|(flags & en)));
endmodule

// File: rtl/dma_req_flag_regs.sv
module dma_req_flag_regs
  import dma_ctl_pkg::*;
#(
  parameter int unsigned NUM_SRC = DEF_NUM_SRC,
  parameter int unsigned NUM_CH  = DEF_NUM_CH,
  parameter int unsigned DW      = DEF_DW,
  localparam int unsigned SRC_W  = $clog2(NUM_SRC)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic                    bus_rd,
  input  logic [DW-1:0]           bus_wdata,
  output logic [DW-1:0]           bus_rdata,
  input  logic [NUM_CH-1:0]       chan_xfer_en,
  input  logic [NUM_CH-1:0]       chan_irq_en,
  input  logic [NUM_CH*SRC_W-1:0] chan_src,
  input  logic [NUM_CH-1:0]       done_pulse,
  input  logic [NUM_CH-1:0]       loop_pulse,
  output logic [NUM_SRC-1:0]      svc_req,
  output logic [NUM_CH-1:0]       chan_start,
  output logic                    irq
);
  logic wr_swreq, wr_flags, rd_flags;
  logic [NUM_CH-1:0] flag_q;

  assign wr_swreq = bus_wr && (reg_sel_e'(bus_sel) == SEL_SWREQ);
  assign wr_flags = bus_wr && (reg_sel_e'(bus_sel) == SEL_FLAGS);
  assign rd_flags = bus_rd && (reg_sel_e'(bus_sel) == SEL_FLAGS);

  dma_swreq_reg #(.NUM_SRC(NUM_SRC), .DW(DW)) u_swreq (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_swreq),
    .wdata (bus_wdata),
    .req_q (svc_req)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_done_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (rd_flags),
      .wr_en   (wr_flags),
      .wbit    (bus_wdata[c]),
      .set_evt (done_pulse[c] | loop_pulse[c]),
      .flag_q  (flag_q[c])
    );

    assign chan_start[c] = chan_xfer_en[c] && svc_req[chan_src[c*SRC_W +: SRC_W]];
  end

  dma_irq_merge #(.NUM_CH(NUM_CH)) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .flags (flag_q),
    .en    (chan_irq_en),
    .irq_q (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (reg_sel_e'(bus_sel) == SEL_SWREQ) bus_rdata[NUM_SRC-1:0] = svc_req;
    else                                  bus_rdata[NUM_CH-1:0]  = flag_q;
  end
endmodule

// File: tb/dma_req_flag_regs_test.sv
`timescale 1ns/1ps
module dma_req_flag_regs_test;
  localparam int SIG_SVC = 0, SIG_CH = 1, SIG_RD = 2, SIG_IRQ = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [2:0] chan_xfer_en = '0, chan_irq_en = '0;
  logic [8:0] chan_src = {3'd7, 3'd5, 3'd2};
  logic [2:0] done_pulse = '0, loop_pulse = '0;
  logic [7:0] svc_req;
  logic [2:0] chan_start;
  logic       irq;

  typedef struct {
    int         due;
    int         sig;
    logic [7:0] val;
    string      req;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  dma_req_flag_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_xfer_en(chan_xfer_en),
    .chan_irq_en(chan_irq_en), .chan_src(chan_src), .done_pulse(done_pulse),
    .loop_pulse(loop_pulse), .svc_req(svc_req), .chan_start(chan_start), .irq(irq)
  );

  function automatic logic [7:0] pick(int sig);
    case (sig)
      SIG_SVC: return svc_req;
      SIG_CH:  return {5'b0, chan_start};
      SIG_RD:  return bus_rdata;
      default: return {7'b0, irq};
    endcase
  endfunction

  // monitor: samples 2 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      cyc++;
      for (int i = q.size() - 1; i >= 0; i--) begin
        if (q[i].due == cyc) begin
          n_checks++;
          if (pick(q[i].sig) !== q[i].val) begin
            n_errors++;
            $display("FAIL %s sig%0d cycle %0d: actual %h expected %h",
                     q[i].req, q[i].sig, cyc, pick(q[i].sig), q[i].val);
          end
          q.delete(i);
        end
      end
    end
  end

  task automatic expect_at(int sig, logic [7:0] val, string req, int dly);
    item_t it;
    it.due = cyc + dly; it.sig = sig; it.val = val; it.req = req;
    q.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_wr(logic sel, logic [7:0] d);
    bus_sel = sel; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(logic sel);
    bus_sel = sel; bus_rd = 1'b1;
    tick();
    bus_rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (4) tick();
    rst_n = 1'b1;
    bus_sel = 1'b1;
    expect_at(SIG_SVC, 8'h00, "R1", 1);
    expect_at(SIG_IRQ, 8'h00, "R1", 1);
    expect_at(SIG_RD,  8'h00, "R1", 1);
    tick();

    expect_at(SIG_SVC, 8'hA5, "R2", 1);
    do_wr(1'b0, 8'hA5);
    expect_at(SIG_RD, 8'hA5, "R2", 1);
    tick();

    expect_at(SIG_SVC, 8'h24, "R3", 1);
    do_wr(1'b0, 8'h24);

    // R4: channels use sources 2, 5, 7; only 2 and 5 pending
    expect_at(SIG_CH, 8'h00, "R4", 1);
    tick();
    chan_xfer_en = 3'b111;
    expect_at(SIG_CH, 8'h03, "R4", 1);
    tick();
    chan_xfer_en = 3'b010;
    expect_at(SIG_CH, 8'h02, "R4", 1);
    tick();
    chan_xfer_en = 3'b111;

    bus_sel = 1'b1;
    done_pulse = 3'b001;
    expect_at(SIG_RD, 8'h01, "R5", 1);
    tick();
    done_pulse = 3'b000;
    loop_pulse = 3'b100;
    expect_at(SIG_RD, 8'h05, "R5", 1);
    tick();
    loop_pulse = 3'b000;

    expect_at(SIG_IRQ, 8'h00, "R10", 1);
    tick();
    chan_irq_en = 3'b100;
    expect_at(SIG_IRQ, 8'h01, "R10", 1);
    tick();

    expect_at(SIG_RD, 8'h05, "R7", 1);
    do_wr(1'b1, 8'h00);

    do_rd(1'b1);
    expect_at(SIG_RD, 8'h04, "R6", 1);
    do_wr(1'b1, 8'h04);
    expect_at(SIG_IRQ, 8'h01, "R10", 1);
    tick();

    expect_at(SIG_RD, 8'h04, "R11", 1);
    do_wr(1'b1, 8'h00);

    expect_at(SIG_RD, 8'h04, "R8", 1);
    do_wr(1'b1, 8'h02);

    do_rd(1'b1);
    expect_at(SIG_RD, 8'h00, "R6", 1);
    expect_at(SIG_IRQ, 8'h01, "R10", 1);
    expect_at(SIG_IRQ, 8'h00, "R10", 2);
    do_wr(1'b1, 8'h00);
    tick();

    // R6: a read showing 0 does not arm
    do_rd(1'b1);
    done_pulse = 3'b010;
    tick();
    done_pulse = 3'b000;
    expect_at(SIG_RD, 8'h02, "R6", 1);
    do_wr(1'b1, 8'h00);

    // R9: pulse and clearing write together
    do_rd(1'b1);
    loop_pulse = 3'b010;
    expect_at(SIG_RD, 8'h02, "R9", 1);
    do_wr(1'b1, 8'h00);
    loop_pulse = 3'b000;
    expect_at(SIG_RD, 8'h02, "R9", 1);
    do_wr(1'b1, 8'h00);

    expect_at(SIG_SVC, 8'h24, "R4", 1);
    tick();
    repeat (3) tick();
    finished = 1'b1;
    finish_run();
  end
endmodule